// File: doc/BRIEF.md
# MDIO Management Frame Engine

This block is a management-bus master for Ethernet PHY devices. The host sees one packed 32-bit command register. One write to it holds the opcode, the PHY address, the PHY register address and the write data. That write starts a complete serial transaction on the clock/data management pair (MDC/MDIO). When the last bit has been clocked, the engine sets a ready flag in the same register. On a read, it also replaces the low half-word with the value the PHY returned. It then raises a single-cycle done event that an interrupt controller can pick up.

The serial side is built as a frame state machine. Its states, in order, are: `ST_IDLE`, `ST_PREAMBLE` (32 ones), `ST_START` (01), `ST_OPCODE` (2 bits), `ST_PHYADDR` (5 bits), `ST_REGADDR` (5 bits), `ST_TURNAROUND` (2 bits), `ST_DATA` (16 bits) and `ST_DONE` (one cycle).

The transitions are:
- IDLE to PREAMBLE on an accepted command.
- From each frame state to the next on the MDC falling edge that ends that state's last bit.
- DATA to DONE on the falling edge that ends bit 0.
- DONE to IDLE unconditionally.

MDC comes from a divider. Each half period is `ceil(CLK_HZ / (2*MDC_MAX_HZ))` system cycles. The engine drives MDIO changes on falling MDC and samples read data on rising MDC.

Top module: `mdio_frame_engine`

## Requirements
- R1: After reset the register reads 0x1000_0000 (ready set, all fields zero), MDC is low, the engine does not drive MDIO and the done output is low.
- R2: Register layout: bits 31:29 read 0, bit 28 is ready, bits 27:26 are the opcode (01 = write, 10 = read), bits 25:21 are the PHY address, bits 20:16 are the register address and bits 15:0 are data. A host write in idle with opcode 01 or 10 stores all fields and clears ready in the next cycle.
- R3: A write frame is 64 MDC periods, all MSB first, in this order: 32 ones, 01, opcode, PHY address, register address, turnaround 10, then the 16 data bits. The engine drives MDIO for every bit.
- R4: A read frame drives the first 46 bits as in R3 with opcode 10. It then releases MDIO for the 2 turnaround bits and the 16 data bits. The data is sampled on rising MDC, MSB first. At completion the data lands in bits 15:0 and the opcode and address fields are kept.
- R5: MDIO output value and drive enable change only while MDC is low, never during a high phase.
- R6: MDC high and low phases each last HALF = ceil(CLK_HZ/(2*MDC_MAX_HZ)) system cycles (50 at the defaults, so MDC is 2.5 MHz at a 250 MHz clock). MDC stays low while idle.
- R7: At completion the done output pulses for exactly one cycle. Ready becomes 1 in that same cycle. There is one pulse per transaction.
- R8: A host write while a transaction is in progress is ignored: the register contents and the frame on the wire are unchanged.
- R9: A host write in idle with opcode 00 or 11 stores the fields but leaves ready at 1. It starts no MDC activity and raises no done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr | input | 1 | Host write strobe for the command register |
| cmd_wdata | input | 32 | Host write value |
| cmd_rdata | output | 32 | Current command register contents |
| mgmt_done | output | 1 | One-cycle completion event |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO value driven by the engine |
| mdio_oe | output | 1 | MDIO drive enable (1 = engine drives) |
| mdio_i | input | 1 | Resolved MDIO line value |

## Verification
The assertions assume the following about the inputs:
- The host write strobe lasts a single cycle.
- Nothing else drives MDIO while the engine's enable is high.
- A PHY changes the line only after falling MDC.

The bench PHY model keeps to this. It drives only during the read turnaround's second bit and the read data bits, and it updates its value on the system edge that follows an MDC fall. The bench also counts any cycle in which both sides drive and treats it as a failure. Host writes are issued as single-cycle pulses on the falling system edge.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] OP_READ  = 2'b10;

    localparam int PRE_BITS  = 32;
    localparam int SOF_BITS  = 2;
    localparam int OP_BITS   = 2;
    localparam int ADDR_BITS = 5;
    localparam int TA_BITS   = 2;
    localparam int DATA_BITS = 16;
    localparam int CNT_W     = $clog2(PRE_BITS);

    localparam int RDY_BIT = 28;
    localparam int OP_LSB  = 26;
    localparam int PHY_LSB = 21;
    localparam int REG_LSB = 16;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_START,
        ST_OPCODE,
        ST_PHYADDR,
        ST_REGADDR,
        ST_TURNAROUND,
        ST_DATA,
        ST_DONE
    } mdio_state_e;
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int HALF_CYCLES = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int CW = $clog2(HALF_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(HALF_CYCLES - 1);

    logic [CW-1:0] div_cnt;
    logic          wrap;

    assign wrap      = run && (div_cnt == LAST);
    assign rise_tick = wrap && !mdc;
    assign fall_tick = wrap && mdc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt <= '0;
            mdc     <= 1'b0;
        end else if (!run) begin
            div_cnt <= '0;
            mdc     <= 1'b0;
        end else if (wrap) begin
            div_cnt <= '0;
            mdc     <= ~mdc;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

    // R6: the frame machine only stops the divider after a falling edge
    a_r6_idle_mdc_low: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !mdc);
endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [1:0]  op,
    input  logic [4:0]  phy_addr,
    input  logic [4:0]  reg_addr,
    input  logic [15:0] wdata,
    input  logic        rise_tick,
    input  logic        fall_tick,
    input  logic        mdio_i,
    output logic        run,
    output logic        busy,
    output logic        finish,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic [15:0] rdata
);
    mdio_state_e      state;
    logic [CNT_W-1:0] bit_cnt;
    logic             is_read;
    logic             last_bit;

    assign is_read  = (op == OP_READ);
    assign last_bit = fall_tick && (bit_cnt == '0);
    assign busy     = (state != ST_IDLE);
    assign run      = busy && (state != ST_DONE);
    assign finish   = (state == ST_DONE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            rdata   <= '0;
        end else begin
            if (state == ST_DATA && is_read && rise_tick)
                rdata <= {rdata[14:0], mdio_i};
            if (fall_tick && bit_cnt != '0)
                bit_cnt <= bit_cnt - 1'b1;
            unique case (state)
                ST_IDLE: if (start) begin
                    state   <= ST_PREAMBLE;
                    bit_cnt <= CNT_W'(PRE_BITS - 1);
                end
                ST_PREAMBLE: if (last_bit) begin
                    state   <= ST_START;
                    bit_cnt <= CNT_W'(SOF_BITS - 1);
                end
                ST_START: if (last_bit) begin
                    state   <= ST_OPCODE;
                    bit_cnt <= CNT_W'(OP_BITS - 1);
                end
                ST_OPCODE: if (last_bit) begin
                    state   <= ST_PHYADDR;
                    bit_cnt <= CNT_W'(ADDR_BITS - 1);
                end
                ST_PHYADDR: if (last_bit) begin
                    state   <= ST_REGADDR;
                    bit_cnt <= CNT_W'(ADDR_BITS - 1);
                end
                ST_REGADDR: if (last_bit) begin
                    state   <= ST_TURNAROUND;
                    bit_cnt <= CNT_W'(TA_BITS - 1);
                end
                ST_TURNAROUND: if (last_bit) begin
                    state   <= ST_DATA;
                    bit_cnt <= CNT_W'(DATA_BITS - 1);
                end
                ST_DATA: if (last_bit) state <= ST_DONE;
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mdio_o  = 1'b0;
        mdio_oe = 1'b1;
        unique case (state)
            ST_IDLE, ST_DONE: mdio_oe = 1'b0;
            ST_PREAMBLE:      mdio_o  = 1'b1;
            ST_START:         mdio_o  = (bit_cnt == '0);
            ST_OPCODE:        mdio_o  = op[bit_cnt[0]];
            ST_PHYADDR:       mdio_o  = phy_addr[bit_cnt[2:0]];
            ST_REGADDR:       mdio_o  = reg_addr[bit_cnt[2:0]];
            ST_TURNAROUND: begin
                mdio_oe = !is_read;
                mdio_o  = !is_read && bit_cnt[0];
            end
            ST_DATA: begin
                mdio_oe = !is_read;
                mdio_o  = !is_read && wdata[bit_cnt[3:0]];
            end
            default:          mdio_oe = 1'b0;
        endcase
    end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_pkg::*;
#(
    parameter int CLK_HZ     = 250_000_000,
    parameter int MDC_MAX_HZ = 2_500_000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_wr,
    input  logic [31:0] cmd_wdata,
    output logic [31:0] cmd_rdata,
    output logic        mgmt_done,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    localparam int HALF = (CLK_HZ + 2 * MDC_MAX_HZ - 1) / (2 * MDC_MAX_HZ);

    logic [1:0]  op_q;
    logic [4:0]  phy_q, reg_q;
    logic [15:0] data_q, rd_data;
    logic        ready_q;
    logic        run, busy, finish, rise_tick, fall_tick;
    logic        valid_op, accept, start;
    logic        unused_hi;

    assign unused_hi = ^cmd_wdata[31:29];
    assign valid_op  = (cmd_wdata[OP_LSB+:2] == OP_WRITE) || (cmd_wdata[OP_LSB+:2] == OP_READ);
    assign accept    = cmd_wr && !busy;
    assign start     = accept && valid_op;
    assign cmd_rdata = {3'b000, ready_q, op_q, phy_q, reg_q, data_q};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q      <= '0;
            phy_q     <= '0;
            reg_q     <= '0;
            data_q    <= '0;
            ready_q   <= 1'b1;
            mgmt_done <= 1'b0;
        end else begin
            mgmt_done <= finish;
            if (finish) begin
                ready_q <= 1'b1;
                if (op_q == OP_READ) data_q <= rd_data;
            end else if (accept) begin
                op_q   <= cmd_wdata[OP_LSB+:2];
                phy_q  <= cmd_wdata[PHY_LSB+:5];
                reg_q  <= cmd_wdata[REG_LSB+:5];
                data_q <= cmd_wdata[15:0];
                if (valid_op) ready_q <= 1'b0;
            end
        end
    end

    mdio_mdc_gen #(.HALF_CYCLES(HALF)) u_div (
        .clk(clk), .rst_n(rst_n), .run(run),
        .mdc(mdc), .rise_tick(rise_tick), .fall_tick(fall_tick)
    );

    mdio_frame_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start),
        .op(op_q), .phy_addr(phy_q), .reg_addr(reg_q), .wdata(data_q),
        .rise_tick(rise_tick), .fall_tick(fall_tick), .mdio_i(mdio_i),
        .run(run), .busy(busy), .finish(finish),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .rdata(rd_data)
    );

    // R5: wire changes confined to the low phase of MDC
    a_r5_stable_when_high: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));
    // R7: done lasts one cycle
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        mgmt_done |=> !mgmt_done);
    // R7: ready rises together with done
    a_r7_ready_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_q) |-> mgmt_done);
    // R8: writes during a transaction leave the fields alone
    a_r8_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && busy && !finish) |=> ($stable(op_q) && $stable(phy_q) && $stable(reg_q)));
endmodule

// File: tb/mdio_frame_engine_bench.sv
module mdio_frame_engine_bench;
    localparam int HALF_EXP = 50;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [31:0] cmd_wdata = '0;
    logic [31:0] cmd_rdata;
    logic        mgmt_done, mdc, mdio_o, mdio_oe, mdio_line;

    logic        phy_oe = 1'b0, phy_val = 1'b0, phy_read = 1'b0;
    logic [15:0] phy_data = '0;
    logic [63:0] fr = '0, oe_bits = '0;
    int k = 0, done_cnt = 0, conflicts = 0;
    int hi_cnt = 0, lo_cnt = 0, last_hi = 0, last_lo = 0;
    int checks = 0, fails = 0, cycles = 0;
    logic prev_mdc = 1'b0;

    always #2 clk = ~clk;

    assign mdio_line = phy_oe ? phy_val : (mdio_oe ? mdio_o : 1'b1);

    mdio_frame_engine u_mdio_frame_engine (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
        .cmd_rdata(cmd_rdata), .mgmt_done(mgmt_done), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_line)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor and PHY model
    always @(negedge clk) begin
        cycles++;
        if (mgmt_done) done_cnt++;
        if (mdc && !prev_mdc) begin
            fr = {fr[62:0], mdio_line};
            oe_bits = {oe_bits[62:0], mdio_oe};
            if (phy_oe && mdio_oe) conflicts++;
            k++;
            last_lo = lo_cnt;
            hi_cnt = 1;
        end else if (!mdc && prev_mdc) begin
            last_hi = hi_cnt;
            lo_cnt = 1;
            if (phy_read && k >= 47 && k <= 63) begin
                phy_oe = 1'b1;
                phy_val = (k == 47) ? 1'b0 : phy_data[63-k];
            end else begin
                phy_oe = 1'b0;
            end
        end else if (mdc) hi_cnt++;
        else lo_cnt++;
        prev_mdc = mdc;
        if (cycles == 190000) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<190000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    task automatic clear_mon();
        k = 0; fr = '0; oe_bits = '0; done_cnt = 0; conflicts = 0;
    endtask

    task automatic host_write(input logic [31:0] v);
        @(negedge clk);
        cmd_wr = 1'b1;
        cmd_wdata = v;
        @(negedge clk);
        cmd_wr = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!mgmt_done && n < 10000) begin
            @(negedge clk);
            n++;
        end
        check("R7 done seen", {63'd0, mgmt_done}, 64'd1);
        check("R7 ready with done", {63'd0, cmd_rdata[28]}, 64'd1);
        @(negedge clk);
        check("R7 done one cycle", {63'd0, mgmt_done}, 64'd0);
    endtask

    function automatic logic [31:0] mk(input logic [1:0] op, input logic [4:0] p,
                                      input logic [4:0] r, input logic [15:0] d);
        return {4'b0000, op, p, r, d};
    endfunction

    task automatic t_reset();
        check("R1 register", {32'd0, cmd_rdata}, {32'd0, 32'h1000_0000});
        check("R1 lines", {61'd0, mdc, mdio_oe, mgmt_done}, 64'd0);
    endtask

    task automatic t_write(input logic [4:0] p, input logic [4:0] r, input logic [15:0] d);
        logic [31:0] c = mk(2'b01, p, r, d);
        clear_mon();
        host_write(c);
        check("R2 ready cleared", {32'd0, cmd_rdata}, {32'd0, c});
        wait_done();
        check("R3 write frame", fr, {32'hFFFF_FFFF, 2'b01, 2'b01, p, r, 2'b10, d});
        check("R3 driven all bits", oe_bits, {64{1'b1}});
        check("R3 bit count", 64'(k), 64'd64);
        check("R6 high phase", 64'(last_hi), 64'(HALF_EXP));
        check("R6 low phase", 64'(last_lo), 64'(HALF_EXP));
        check("R6 idle mdc low", {63'd0, mdc}, 64'd0);
        check("R7 single pulse", 64'(done_cnt), 64'd1);
        check("R2 fields kept", {32'd0, cmd_rdata}, {32'd0, c | 32'h1000_0000});
        check("R5 no contention", 64'(conflicts), 64'd0);
    endtask

    task automatic t_read(input logic [4:0] p, input logic [4:0] r, input logic [15:0] v);
        logic [31:0] c = mk(2'b10, p, r, 16'h5A5A);
        clear_mon();
        phy_read = 1'b1;
        phy_data = v;
        host_write(c);
        check("R2 ready cleared read", {63'd0, cmd_rdata[28]}, 64'd0);
        wait_done();
        phy_read = 1'b0;
        check("R4 read header", {18'd0, fr[63:18]}, {18'd0, 32'hFFFF_FFFF, 2'b01, 2'b10, p, r});
        check("R4 released", oe_bits, {{46{1'b1}}, 18'd0});
        check("R4 read data", {32'd0, cmd_rdata}, {32'd0, 4'b0001, 2'b10, p, r, v});
        check("R5 no contention read", 64'(conflicts), 64'd0);
    endtask

    task automatic t_busy();
        logic [31:0] a = mk(2'b01, 5'h03, 5'h11, 16'h1234);
        logic [31:0] b = mk(2'b10, 5'h1C, 5'h05, 16'hFFFF);
        clear_mon();
        host_write(a);
        repeat (1000) @(negedge clk);
        host_write(b);
        check("R8 register unchanged", {32'd0, cmd_rdata}, {32'd0, a});
        wait_done();
        check("R8 frame of first command", fr, {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h03, 5'h11, 2'b10, 16'h1234});
        check("R8 single completion", 64'(done_cnt), 64'd1);
    endtask

    task automatic t_bad(input logic [1:0] op);
        logic [31:0] c = mk(op, 5'h0A, 5'h15, 16'hBEEF);
        clear_mon();
        host_write(c);
        check("R9 stored, ready kept", {32'd0, cmd_rdata}, {32'd0, c | 32'h1000_0000});
        repeat (300) @(negedge clk);
        check("R9 no mdc", 64'(k), 64'd0);
        check("R9 no done", 64'(done_cnt), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write(5'h01, 5'h00, 16'h8000);
        t_write(5'h1E, 5'h1B, 16'h6C39);
        t_read(5'h1F, 5'h02, 16'hA5C3);
        t_read(5'h00, 5'h1F, 16'h8001);
        t_busy();
        t_bad(2'b00);
        t_bad(2'b11);
        t_write(5'h15, 5'h0A, 16'h0001);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule